// File: doc/BRIEF.md
# TDM Synchronous Serial Port

This block is a synchronous serial port for codecs and for links to other processors. It has one receive section and a set of transmit lanes, each section with its own enable. The bit clocks and frame syncs come from outside. They are sampled in the system clock domain, and each rising bit-clock edge becomes a one-cycle tick. A frame begins at a tick where the one-bit-wide frame sync is high. That bit is the MSB of slot 0.

There are two channel modes. In synchronous mode the receiver follows the transmit bit clock and frame sync, and up to three transmit lanes may run. In asynchronous mode the receiver runs from its own bit clock and frame sync, and only lane 0 may be enabled. There are also two framing modes. Normal mode moves one word per frame. Network mode moves a programmable number of time slots per frame, up to 32, and a mask turns each slot on or off.

Software loads each lane through a one-word holding register and collects received words from a one-word output register. Two sticky flags report late service: underrun on the transmit side and overrun on the receive side.

Top module: `ssp_tdm_port`

## Requirements
- R1: After reset, `txd_oe` and `txd` are all 0, `rx_full`, `rx_overrun` and `tx_underrun` are 0, and `tx_req` is 0 while `tx_en` is 0.
- R2: The word length is set by `wlen`: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 24 bits. A transmitted word is the low word-length bits of the written data, sent MSB first, one bit per bit-clock tick.
- R3: In normal mode only slot 0 is used. `txd_oe` is high for exactly the word-length bits that start at the frame-sync bit. After that the output is idle (`txd_oe`=0, `txd`=0) until the next frame sync.
- R4: In network mode a frame holds slots 0 to `slot_last`. Slot k is active only when `slot_mask[k]` is 1. During an inactive slot `txd_oe` and `txd` are 0.
- R5: The receiver shifts in each active slot MSB first. At the slot's last bit it presents the word, right-aligned and zero-extended, on `rx_data`, the slot number on `rx_slot`, and sets `rx_full`. Bits of inactive slots are discarded and leave `rx_full` unchanged.
- R6: In synchronous mode all three lanes may transmit in the same slots. The receiver frames on `tx_sclk`/`tx_fs`, and `rx_sclk`/`rx_fs` have no effect.
- R7: In asynchronous mode enable requests for lanes 1 and 2 are ignored: their `txd_oe` and `tx_req` stay 0. The receiver frames on `rx_sclk`/`rx_fs` independently of the transmit side.
- R8: If an active slot starts while an enabled lane's holding register is empty, that lane sends all zeros in the slot and sets its `tx_underrun`. A write to the lane clears the flag.
- R9: If a word completes while `rx_full` is still set, `rx_overrun` is set and `rx_data` takes the newer word. `rx_rd` clears both `rx_full` and `rx_overrun`.
- R10: `tx_req[i]` is high while lane i is enabled and its holding register is empty. A write drops it, and it is 0 while the lane is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1: synchronous channel mode, 0: asynchronous |
| net_mode | input | 1 | 1: network (multi-slot) framing, 0: normal |
| wlen | input | 2 | Word length code (0: 8, 1: 16, 2/3: 24 bits) |
| slot_last | input | 5 | Index of the last slot of a network frame |
| slot_mask | input | 32 | Per-slot active bit for network mode |
| tx_en | input | 3 | Per-lane transmit enable request |
| rx_en | input | 1 | Receiver enable |
| tx_sclk | input | 1 | Transmit-side bit clock |
| tx_fs | input | 1 | Transmit-side frame sync |
| rx_sclk | input | 1 | Receive-side bit clock (asynchronous mode) |
| rx_fs | input | 1 | Receive-side frame sync (asynchronous mode) |
| rxd | input | 1 | Serial receive data |
| tx_wr | input | 3 | Per-lane holding register write strobe |
| tx_wdata | input | 72 | Per-lane write data, lane i at bits [24i+23:24i] |
| tx_req | output | 3 | Per-lane holding register empty and lane enabled |
| tx_underrun | output | 3 | Per-lane sticky underrun flag |
| txd | output | 3 | Per-lane serial transmit data |
| txd_oe | output | 3 | Per-lane output drive enable (0 = high impedance) |
| rx_rd | input | 1 | Read strobe for the receive word |
| rx_data | output | 24 | Last received word |
| rx_slot | output | 5 | Slot number of `rx_data` |
| rx_full | output | 1 | Receive word waiting |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
Directed frames come first. They walk normal mode through all three word lengths, so a wrong bit order or a wrong alignment of short words shows up. A network frame with a sparse mask and three lanes separates slot gating from slot counting. An asynchronous pair of frames shows that the receiver is driven by its own sync and that lanes 1 and 2 stay silent. Further frames drop one holding-register write or skip every receive read, which shows that the underrun and overrun paths are distinct from normal data flow. Constrained random frames then vary the mode, word length, slot count, mask, lane enables and data, and each slot is compared with a bench model of the expected bits and receive words.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [1:0] {
    WL_8  = 2'd0,
    WL_16 = 2'd1,
    WL_24 = 2'd2
  } wlen_e;

  // Number of data bits carried per slot for a word-length code.
  function automatic int unsigned wlen_bits(input logic [1:0] code);
    case (code)
      WL_8:    return 8;
      WL_16:   return 16;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/ssp_line_sync.sv
module ssp_line_sync (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic fs,
  output logic tick,
  output logic fs_s
);

  logic s0_q, s1_q, fs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
      fs_q <= 1'b0;
    end else begin
      s0_q <= sclk;
      s1_q <= s0_q;
      fs_q <= fs;
    end
  end

  assign tick = s0_q & ~s1_q;
  assign fs_s = fs_q;

endmodule

// File: rtl/ssp_framer.sv
module ssp_framer #(
  parameter int MAX_SLOTS = 32,
  parameter int DW        = 24,
  localparam int SLOT_W   = $clog2(MAX_SLOTS),
  localparam int BCNT_W   = $clog2(DW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              fs,
  input  logic              net_mode,
  input  logic [1:0]        wlen,
  input  logic [SLOT_W-1:0] slot_last,
  input  logic [MAX_SLOTS-1:0] slot_mask,
  output logic              pos_tick,
  output logic              pos_valid,
  output logic              pos_on,
  output logic              pos_first,
  output logic              pos_last,
  output logic [SLOT_W-1:0] pos_slot
);

  logic              run_q;
  logic [BCNT_W-1:0] bit_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BCNT_W-1:0] cur_bit;
  logic [BCNT_W-1:0] last_bit;
  logic [SLOT_W-1:0] max_slot;

  always_comb begin
    last_bit  = BCNT_W'(ssp_pkg::wlen_bits(wlen) - 1);
    max_slot  = net_mode ? slot_last : '0;
    cur_bit   = fs ? '0 : bit_q;
    pos_slot  = fs ? '0 : slot_q;
    pos_tick  = tick;
    pos_valid = tick & (fs | run_q);
    pos_first = (cur_bit == '0);
    pos_last  = (cur_bit == last_bit);
    pos_on    = net_mode ? slot_mask[pos_slot] : (pos_slot == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      bit_q  <= '0;
      slot_q <= '0;
    end else if (pos_valid) begin
      if (pos_last) begin
        bit_q <= '0;
        if (pos_slot == max_slot) begin
          run_q  <= 1'b0;
          slot_q <= '0;
        end else begin
          run_q  <= 1'b1;
          slot_q <= pos_slot + 1'b1;
        end
      end else begin
        run_q  <= 1'b1;
        bit_q  <= cur_bit + 1'b1;
        slot_q <= pos_slot;
      end
    end
  end

endmodule

// File: rtl/ssp_tx_lane.sv
module ssp_tx_lane #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [1:0]    wlen,
  input  logic          pos_tick,
  input  logic          pos_valid,
  input  logic          pos_on,
  input  logic          pos_first,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic          txd,
  output logic          oe,
  output logic          req,
  output logic          underrun
);

  logic [DW-1:0] hold_q;
  logic          full_q;
  logic [DW-1:0] sh_q;
  logic [DW-1:0] load_word;
  int unsigned   nb;

  always_comb begin
    nb        = ssp_pkg::wlen_bits(wlen);
    load_word = full_q ? (hold_q << (DW - nb)) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      full_q   <= 1'b0;
      sh_q     <= '0;
      txd      <= 1'b0;
      oe       <= 1'b0;
      underrun <= 1'b0;
    end else if (!en) begin
      full_q   <= 1'b0;
      txd      <= 1'b0;
      oe       <= 1'b0;
      underrun <= 1'b0;
    end else begin
      if (pos_valid && pos_on) begin
        oe <= 1'b1;
        if (pos_first) begin
          txd    <= load_word[DW-1];
          sh_q   <= load_word << 1;
          full_q <= 1'b0;
          if (!full_q) underrun <= 1'b1;
        end else begin
          txd  <= sh_q[DW-1];
          sh_q <= sh_q << 1;
        end
      end else if (pos_tick) begin
        oe  <= 1'b0;
        txd <= 1'b0;
      end
      if (wr) begin
        hold_q   <= wdata;
        full_q   <= 1'b1;
        underrun <= 1'b0;
      end
    end
  end

  assign req = en & ~full_q;

endmodule

// File: rtl/ssp_rx_lane.sv
module ssp_rx_lane #(
  parameter int DW     = 24,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        wlen,
  input  logic              pos_valid,
  input  logic              pos_on,
  input  logic              pos_first,
  input  logic              pos_last,
  input  logic [SLOT_W-1:0] pos_slot,
  input  logic              rxd,
  input  logic              rd,
  output logic [DW-1:0]     data,
  output logic [SLOT_W-1:0] slot,
  output logic              full,
  output logic              overrun
);

  logic [DW-1:0] sh_q;
  logic [DW-1:0] acc_next;
  logic [DW-1:0] wmask;

  always_comb begin
    wmask    = ~({DW{1'b1}} << ssp_pkg::wlen_bits(wlen));
    acc_next = pos_first ? {{(DW-1){1'b0}}, rxd} : {sh_q[DW-2:0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      data    <= '0;
      slot    <= '0;
      full    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (rd) begin
        full    <= 1'b0;
        overrun <= 1'b0;
      end
      if (en && pos_valid && pos_on) begin
        sh_q <= acc_next;
        if (pos_last) begin
          data <= acc_next & wmask;
          slot <= pos_slot;
          full <= 1'b1;
          if (full && !rd) overrun <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ssp_tdm_port.sv
module ssp_tdm_port #(
  parameter int NUM_TX    = 3,
  parameter int DW        = 24,
  parameter int MAX_SLOTS = 32,
  localparam int SLOT_W   = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sync_mode,
  input  logic                 net_mode,
  input  logic [1:0]           wlen,
  input  logic [SLOT_W-1:0]    slot_last,
  input  logic [MAX_SLOTS-1:0] slot_mask,
  input  logic [NUM_TX-1:0]    tx_en,
  input  logic                 rx_en,
  input  logic                 tx_sclk,
  input  logic                 tx_fs,
  input  logic                 rx_sclk,
  input  logic                 rx_fs,
  input  logic                 rxd,
  input  logic [NUM_TX-1:0]    tx_wr,
  input  logic [NUM_TX*DW-1:0] tx_wdata,
  output logic [NUM_TX-1:0]    tx_req,
  output logic [NUM_TX-1:0]    tx_underrun,
  output logic [NUM_TX-1:0]    txd,
  output logic [NUM_TX-1:0]    txd_oe,
  input  logic                 rx_rd,
  output logic [DW-1:0]        rx_data,
  output logic [SLOT_W-1:0]    rx_slot,
  output logic                 rx_full,
  output logic                 rx_overrun
);

  logic t_tick, t_fs, r_tick, r_fs;
  logic rxd_q;
  logic [NUM_TX-1:0] en_eff;

  logic              tp_tick, tp_valid, tp_on, tp_first, tp_last;
  logic [SLOT_W-1:0] tp_slot;
  logic              rp_tick, rp_valid, rp_on, rp_first, rp_last;
  logic [SLOT_W-1:0] rp_slot;

  ssp_line_sync u_tx_sync (
    .clk(clk), .rst(rst), .sclk(tx_sclk), .fs(tx_fs), .tick(t_tick), .fs_s(t_fs)
  );

  ssp_line_sync u_rx_sync (
    .clk(clk), .rst(rst), .sclk(rx_sclk), .fs(rx_fs), .tick(r_tick), .fs_s(r_fs)
  );

  always_ff @(posedge clk) begin
    if (rst) rxd_q <= 1'b0;
    else     rxd_q <= rxd;
  end

  ssp_framer #(.MAX_SLOTS(MAX_SLOTS), .DW(DW)) u_tx_frm (
    .clk(clk), .rst(rst), .tick(t_tick), .fs(t_fs),
    .net_mode(net_mode), .wlen(wlen), .slot_last(slot_last), .slot_mask(slot_mask),
    .pos_tick(tp_tick), .pos_valid(tp_valid), .pos_on(tp_on),
    .pos_first(tp_first), .pos_last(tp_last), .pos_slot(tp_slot)
  );

  ssp_framer #(.MAX_SLOTS(MAX_SLOTS), .DW(DW)) u_rx_frm (
    .clk(clk), .rst(rst),
    .tick(sync_mode ? t_tick : r_tick), .fs(sync_mode ? t_fs : r_fs),
    .net_mode(net_mode), .wlen(wlen), .slot_last(slot_last), .slot_mask(slot_mask),
    .pos_tick(rp_tick), .pos_valid(rp_valid), .pos_on(rp_on),
    .pos_first(rp_first), .pos_last(rp_last), .pos_slot(rp_slot)
  );

  for (genvar i = 0; i < NUM_TX; i++) begin : g_lane
    if (i == 0) begin : g_prim
      assign en_eff[i] = tx_en[i];
    end else begin : g_extra
      assign en_eff[i] = tx_en[i] & sync_mode;
    end

    ssp_tx_lane #(.DW(DW)) u_lane (
      .clk(clk), .rst(rst), .en(en_eff[i]), .wlen(wlen),
      .pos_tick(tp_tick), .pos_valid(tp_valid), .pos_on(tp_on), .pos_first(tp_first),
      .wr(tx_wr[i]), .wdata(tx_wdata[i*DW +: DW]),
      .txd(txd[i]), .oe(txd_oe[i]), .req(tx_req[i]), .underrun(tx_underrun[i])
    );
  end

  ssp_rx_lane #(.DW(DW), .SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst(rst), .en(rx_en), .wlen(wlen),
    .pos_valid(rp_valid), .pos_on(rp_on), .pos_first(rp_first), .pos_last(rp_last),
    .pos_slot(rp_slot), .rxd(rxd_q), .rd(rx_rd),
    .data(rx_data), .slot(rx_slot), .full(rx_full), .overrun(rx_overrun)
  );

  logic unused_rp_tick;
  assign unused_rp_tick = rp_tick;

endmodule

// File: rtl/ssp_tdm_chk.sv
module ssp_tdm_chk #(
  parameter int NUM_TX = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_mode,
  input logic [NUM_TX-1:0] tx_en,
  input logic [NUM_TX-1:0] tx_wr,
  input logic [NUM_TX-1:0] tx_req,
  input logic [NUM_TX-1:0] tx_underrun,
  input logic [NUM_TX-1:0] txd,
  input logic [NUM_TX-1:0] txd_oe,
  input logic              rx_rd,
  input logic              rx_full,
  input logic              rx_overrun
);

  // R7
  async_lanes_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !sync_mode |=> ((txd_oe >> 1) == '0));

  // R10
  write_fills_holding_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_wr[0] && tx_en[0]) |=> (!tx_req[0] || !tx_en[0]));

  // R8
  write_clears_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_wr[0] && tx_en[0]) |=> !tx_underrun[0]);

  // R9
  overrun_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> rx_full);

  // R9
  read_clears_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    rx_rd |=> !rx_overrun);

  // R4
  idle_line_low_chk: assert property (@(posedge clk) disable iff (rst)
    !txd_oe[0] |-> !txd[0]);

  // R3
  disabled_lane_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en[0] |=> !txd_oe[0]);

endmodule

bind ssp_tdm_port ssp_tdm_chk #(.NUM_TX(NUM_TX)) u_chk (.*);

// File: tb/tb_ssp_tdm_port.sv
module tb_ssp_tdm_port;
  localparam int NT = 3;
  localparam int DW = 24;
  localparam int MS = 32;
  localparam int SW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, sync_mode, net_mode, rx_en;
  logic [1:0] wlen;
  logic [SW-1:0] slot_last;
  logic [MS-1:0] slot_mask;
  logic [NT-1:0] tx_en, tx_wr, tx_req, tx_underrun, txd, txd_oe;
  logic tx_sclk, tx_fs, rx_sclk, rx_fs, rxd, rx_rd;
  logic [NT*DW-1:0] tx_wdata;
  logic [DW-1:0] rx_data;
  logic [SW-1:0] rx_slot;
  logic rx_full, rx_overrun;

  ssp_tdm_port dut (
    .clk(clk), .rst(rst), .sync_mode(sync_mode), .net_mode(net_mode), .wlen(wlen),
    .slot_last(slot_last), .slot_mask(slot_mask), .tx_en(tx_en), .rx_en(rx_en),
    .tx_sclk(tx_sclk), .tx_fs(tx_fs), .rx_sclk(rx_sclk), .rx_fs(rx_fs), .rxd(rxd),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_req(tx_req), .tx_underrun(tx_underrun),
    .txd(txd), .txd_oe(txd_oe), .rx_rd(rx_rd), .rx_data(rx_data), .rx_slot(rx_slot),
    .rx_full(rx_full), .rx_overrun(rx_overrun)
  );

  int checks = 0;
  int fails  = 0;
  logic [DW-1:0] wq [NT][MS];
  logic [DW-1:0] rw [MS];
  int  skip_slot = -1;
  bit  rd_skip   = 1'b0;
  bit  rx_clk_on = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int bits_of(input logic [1:0] c);
    return (c == 2'd0) ? 8 : (c == 2'd1) ? 16 : 24;
  endfunction

  function automatic logic [DW-1:0] wmask();
    return ~({DW{1'b1}} << bits_of(wlen));
  endfunction

  function automatic bit act(input int s);
    return net_mode ? slot_mask[s] : (s == 0);
  endfunction

  function automatic bit en_of(input int i);
    return tx_en[i] && (sync_mode || i == 0);
  endfunction

  function automatic int nsl();
    return net_mode ? int'(slot_last) + 1 : 1;
  endfunction

  function automatic int next_act(input int s);
    for (int k = s + 1; k < nsl(); k++) if (act(k)) return k;
    return -1;
  endfunction

  task automatic fill();
    for (int s = 0; s < MS; s++) begin
      rw[s] = DW'($urandom);
      for (int i = 0; i < NT; i++) wq[i][s] = DW'($urandom);
    end
  endtask

  task automatic step(input bit ft, input bit fr, input bit d);
    @(negedge clk);
    tx_fs = ft; rx_fs = fr; rxd = d; tx_sclk = 1'b1; rx_sclk = rx_clk_on;
    repeat (4) @(negedge clk);
    tx_sclk = 1'b0; rx_sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_writes(input int s);
    @(negedge clk);
    for (int i = 0; i < NT; i++) begin
      if (en_of(i)) begin
        chk(tx_req[i] == 1'b1, "R10", "tx_req before write", 32'(tx_req[i]), 1);
        if (s != skip_slot) begin
          tx_wr[i] = 1'b1;
          tx_wdata[i*DW +: DW] = wq[i][s];
        end
      end else begin
        chk(tx_req[i] == 1'b0, "R7", "tx_req of disabled lane", 32'(tx_req[i]), 0);
      end
    end
    @(negedge clk);
    tx_wr = '0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic run_frame(input bit ft_on, input bit fr_on);
    int n, b, nread, last_wr, fa;
    bit framed_rx;
    logic [DW-1:0] got [NT];
    bit oall [NT];
    bit oany [NT];
    n = nsl(); b = bits_of(wlen); nread = 0; last_wr = -1;
    framed_rx = sync_mode ? ft_on : fr_on;
    fa = act(0) ? 0 : next_act(0);
    if (ft_on && fa >= 0) begin do_writes(fa); last_wr = fa; end
    for (int s = 0; s < n; s++) begin
      for (int i = 0; i < NT; i++) begin got[i] = '0; oall[i] = 1'b1; oany[i] = 1'b0; end
      for (int bb = 0; bb < b; bb++) begin
        step(ft_on && s == 0 && bb == 0, fr_on && s == 0 && bb == 0, rw[s][b-1-bb]);
        for (int i = 0; i < NT; i++) begin
          got[i]  = {got[i][DW-2:0], txd[i]};
          oall[i] = oall[i] & txd_oe[i];
          oany[i] = oany[i] | txd_oe[i];
        end
      end
      for (int i = 0; i < NT; i++) begin
        if (ft_on && act(s) && en_of(i)) begin
          logic [DW-1:0] ew;
          ew = (s == skip_slot) ? '0 : (wq[i][s] & wmask());
          chk(oall[i] && ((got[i] & wmask()) == ew), "R2",
              $sformatf("lane %0d slot %0d word", i, s), got[i] & wmask(), ew);
          chk(tx_underrun[i] == (s == skip_slot), "R8",
              $sformatf("lane %0d slot %0d underrun", i, s), 32'(tx_underrun[i]),
              32'(s == skip_slot));
        end else begin
          chk(!oany[i], "R4", $sformatf("lane %0d slot %0d quiet", i, s),
              32'(oany[i]), 0);
        end
      end
      if (framed_rx && act(s) && rx_en) begin
        nread++;
        chk(rx_full && rx_data == (rw[s] & wmask()) && int'(rx_slot) == s, "R5",
            $sformatf("rx slot %0d word", s), rx_data, rw[s] & wmask());
        chk(rx_overrun == (rd_skip && nread > 1), "R9", "rx_overrun",
            32'(rx_overrun), 32'(rd_skip && nread > 1));
        if (!rd_skip) pulse_rd();
      end else begin
        chk(rx_full == (rd_skip && nread > 0), "R5", $sformatf("rx slot %0d discard", s),
            32'(rx_full), 32'(rd_skip && nread > 0));
      end
      if (ft_on && next_act(s) > last_wr) begin
        last_wr = next_act(s);
        do_writes(last_wr);
      end
    end
    for (int k = 0; k < 2; k++) begin
      step(1'b0, 1'b0, 1'b0);
      chk(txd_oe == '0 && txd == '0, "R3", "idle after frame", {txd_oe, txd}, 0);
    end
    if (rd_skip && nread > 0) begin
      pulse_rd();
      chk(!rx_full && !rx_overrun, "R9", "read clears flags", {rx_full, rx_overrun}, 0);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; sync_mode = 1'b1; net_mode = 1'b0; wlen = 2'd0; slot_last = '0;
    slot_mask = '0; tx_en = '0; rx_en = 1'b1; tx_sclk = 0; tx_fs = 0; rx_sclk = 0;
    rx_fs = 0; rxd = 0; tx_wr = '0; tx_wdata = '0; rx_rd = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(txd_oe == '0 && txd == '0, "R1", "tx lines after reset", {txd_oe, txd}, 0);
    chk(!rx_full && !rx_overrun, "R1", "rx flags after reset", {rx_full, rx_overrun}, 0);
    chk(tx_req == '0 && tx_underrun == '0, "R1", "tx flags after reset",
        {tx_req, tx_underrun}, 0);

    // R2 R3: normal mode, each word length
    tx_en = 3'b001;
    for (int c = 0; c < 3; c++) begin
      wlen = 2'(c); fill();
      run_frame(1'b1, 1'b0);
    end

    // R4 R5 R6: network, sparse mask, three lanes, rx clock lines idle
    net_mode = 1'b1; wlen = 2'd0; slot_last = 5'd3; slot_mask = 32'b1011;
    tx_en = 3'b111; fill();
    run_frame(1'b1, 1'b0);

    // R8: one holding register write skipped
    skip_slot = 1; fill();
    run_frame(1'b1, 1'b0);
    skip_slot = -1;

    // R9: receive reads skipped
    rd_skip = 1'b1; fill();
    run_frame(1'b1, 1'b0);
    rd_skip = 1'b0;

    // R7: asynchronous mode
    sync_mode = 1'b0; rx_clk_on = 1'b1; wlen = 2'd1; fill();
    run_frame(1'b0, 1'b1);
    run_frame(1'b1, 1'b0);
    sync_mode = 1'b1; rx_clk_on = 1'b0;

    // R10: disabling a lane drops its request
    tx_en = 3'b000;
    @(negedge clk);
    chk(tx_req == '0, "R10", "tx_req after disable", 32'(tx_req), 0);

    // R2 R4 R5 R6: random frames
    for (int f = 0; f < 16; f++) begin
      net_mode  = 1'($urandom);
      wlen      = 2'($urandom_range(0, 3));
      slot_last = 5'($urandom_range(0, 5));
      slot_mask = $urandom;
      tx_en     = 3'($urandom);
      fill();
      run_frame(1'b1, 1'b0);
    end

    summary();
    $finish;
  end

endmodule